// File: doc/BRIEF.md
# CVSD Calibration Pattern Source with Run Density Monitor

This block is a test source for the digital side of a continuously variable slope delta codec. It serialises one of four fixed, endlessly repeating bit words that are used to set and check a decoder's output level, one bit per bit-clock enable. Two select inputs choose the word: a rate select picks the 16 kbps word (20-bit period) or the 32 kbps word (40-bit period), and a density select picks the word in which no three consecutive bits are equal or the word in which three-alike runs end on exactly 30% of the bit positions. The 30% words set the 0 dB reference level of a decoder; the other two should come out about 24 dB lower.

A change on either select is only sampled when the bit index is back at zero, so every period on the line is a whole, clean word. Next to the source sits a density monitor. It counts the overload-flag pulses that an external encoder or decoder under test returns over each pattern period, reports the tally at the period boundary, and raises an error when the tally differs from the run count of the selected word. A bench or a board test can then confirm the run-of-three logic of a codec without any analog measurement.

The monitor is a three-state machine. M_IDLE is the state after reset, before any period has started. The first enable (which is always a boundary) moves M_IDLE to M_WARM. At every later boundary the monitor reports the period that just ended and moves to M_CHECK when the new period uses the same selection as the old one, or back to M_WARM when the selection changed. Only a period run in M_CHECK is compared against its expected count, because a warm period still holds overload flags that stem from the bits of the previous word.

Top module: `cvsd_refgen`

## Requirements
- R1: While reset is low and after it is released, ser_bit, bit_first, act_rate, act_dens, duty_cnt, duty_valid and density_err are all 0.
- R2: With rate_sel=0 and dens_sel=0 the source emits the 20-bit word 0xDB492 most significant bit first, repeated without gaps.
- R3: With rate_sel=0 and dens_sel=1 the source emits the 20-bit word 0xFB412 most significant bit first, repeated without gaps.
- R4: With rate_sel=1 and dens_sel=0 the source emits the 40-bit word 0xDB54924AB6 most significant bit first, repeated without gaps.
- R5: With rate_sel=1 and dens_sel=1 the source emits the 40-bit word 0xFDAA10255E most significant bit first, repeated without gaps.
- R6: ser_bit, bit_first, act_rate and act_dens change only on the clock edge at which bit_en is high, and show the new bit from the following cycle until the next enable; enables may come back to back.
- R7: bit_first is 1 exactly while ser_bit holds the first bit of a period, and act_rate/act_dens show the selection that the current period uses.
- R8: rate_sel and dens_sel are sampled only at an enable where the bit index is zero; a change anywhere inside a period has no effect on the bits of that period.
- R9: The monitor samples ovl_in at each enable; the tally of a period covers the enables of its bits two to last plus the enable that starts the next period, and is shown on duty_cnt with a one-cycle duty_valid pulse in the cycle after that boundary enable.
- R10: For a period run in M_CHECK, density_err pulses together with duty_valid when the tally differs from the expected count (0 for both 0% words, 6 for the 20-bit 30% word, 12 for the 40-bit 30% word); density_err is 0 in every cycle without duty_valid.
- R11: The first period after reset and the first period after any selection change run in M_WARM and are reported without a comparison, so density_err stays 0 for them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Bit-clock enable, one bit per high cycle |
| rate_sel | input | 1 | 0 selects the 20-bit (16 kbps) word, 1 the 40-bit (32 kbps) word |
| dens_sel | input | 1 | 0 selects the 0% run word, 1 the 30% run word |
| ovl_in | input | 1 | Overload flag returned by the codec under test |
| ser_bit | output | 1 | Serial pattern bit |
| bit_first | output | 1 | High while ser_bit is the first bit of a period |
| act_rate | output | 1 | Rate selection in use for the current period |
| act_dens | output | 1 | Density selection in use for the current period |
| duty_cnt | output | 6 | Overload-flag tally of the last reported period |
| duty_valid | output | 1 | One-cycle pulse when duty_cnt is updated |
| density_err | output | 1 | One-cycle pulse when a checked tally misses the expected count |

## Verification
A wrong bit index shows on ser_bit at the very next enable and breaks the bit_first marker within one period, so the scoreboard sees it within 40 enables at most. A selection register that moves mid-period shows at once on act_rate/act_dens and in the following bits. A tally or monitor state that goes astray only becomes visible at the next boundary, either as a wrong duty_cnt or as a density_err that fires in a warm period or stays silent on a deliberately corrupted checked period, so the bench injects one flipped overload flag and crosses selection changes both at and away from the boundary.

// File: rtl/cvsd_refgen_pkg.sv
`timescale 1ns/1ps
package cvsd_refgen_pkg;

    localparam int unsigned SHORT_LEN = 20;
    localparam int unsigned LONG_LEN  = 40;
    localparam int unsigned PAD_LEN   = LONG_LEN - SHORT_LEN;
    localparam int unsigned IDX_W     = $clog2(LONG_LEN);
    localparam int unsigned CNT_W     = $clog2(LONG_LEN + 1);

    // All words are left-aligned in a LONG_LEN field, first bit on the left.
    localparam logic [LONG_LEN-1:0] WORD_Q16 = {20'hDB492, {PAD_LEN{1'b0}}};
    localparam logic [LONG_LEN-1:0] WORD_D16 = {20'hFB412, {PAD_LEN{1'b0}}};
    localparam logic [LONG_LEN-1:0] WORD_Q32 = 40'hDB54924AB6;
    localparam logic [LONG_LEN-1:0] WORD_D32 = 40'hFDAA10255E;

    typedef struct packed {
        logic wide;   // 1: 40-bit period
        logic dense;  // 1: 30% run word
    } sel_t;

    function automatic logic word_bit(logic [LONG_LEN-1:0] w, int unsigned k);
        return 1'(w >> (LONG_LEN - 1 - k));
    endfunction

    // Cyclic count of positions that close a run of three equal bits.
    function automatic int unsigned count_runs(logic [LONG_LEN-1:0] w, int unsigned len);
        int unsigned n;
        int unsigned p1;
        int unsigned p2;
        n = 0;
        for (int unsigned k = 0; k < LONG_LEN; k++) begin
            if (k < len) begin
                p1 = (k + len - 1) % len;
                p2 = (k + len - 2) % len;
                if ((word_bit(w, k) == word_bit(w, p1)) && (word_bit(w, k) == word_bit(w, p2)))
                    n++;
            end
        end
        return n;
    endfunction

    localparam int unsigned RUNS_Q16 = count_runs(WORD_Q16, SHORT_LEN);
    localparam int unsigned RUNS_D16 = count_runs(WORD_D16, SHORT_LEN);
    localparam int unsigned RUNS_Q32 = count_runs(WORD_Q32, LONG_LEN);
    localparam int unsigned RUNS_D32 = count_runs(WORD_D32, LONG_LEN);

    function automatic logic [LONG_LEN-1:0] sel_word(sel_t s);
        logic [LONG_LEN-1:0] w;
        case ({s.wide, s.dense})
            2'b00:   w = WORD_Q16;
            2'b01:   w = WORD_D16;
            2'b10:   w = WORD_Q32;
            default: w = WORD_D32;
        endcase
        return w;
    endfunction

    function automatic logic [IDX_W-1:0] sel_last(sel_t s);
        return s.wide ? IDX_W'(LONG_LEN - 1) : IDX_W'(SHORT_LEN - 1);
    endfunction

    function automatic logic sel_bit(sel_t s, logic [IDX_W-1:0] i);
        return 1'(sel_word(s) >> (IDX_W'(LONG_LEN - 1) - i));
    endfunction

    function automatic logic [CNT_W-1:0] sel_runs(sel_t s);
        logic [CNT_W-1:0] r;
        case ({s.wide, s.dense})
            2'b00:   r = CNT_W'(RUNS_Q16);
            2'b01:   r = CNT_W'(RUNS_D16);
            2'b10:   r = CNT_W'(RUNS_Q32);
            default: r = CNT_W'(RUNS_D32);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cvsd_refgen_seq.sv
`timescale 1ns/1ps
module cvsd_refgen_seq
    import cvsd_refgen_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  sel_t sel_req,
    output logic ser_bit,
    output logic bit_first,
    output sel_t sel_cur,
    output logic at_wrap
);

    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] idx_d;
    sel_t             sel_d;
    logic             bit_d;

    always_comb begin
        at_wrap = bit_en && (idx_q == '0);
        sel_d   = at_wrap ? sel_req : sel_cur;
        bit_d   = sel_bit(sel_d, idx_q);
        idx_d   = idx_q;
        if (bit_en) begin
            idx_d = (idx_q == sel_last(sel_d)) ? '0 : idx_q + IDX_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q     <= '0;
            sel_cur   <= '0;
            ser_bit   <= 1'b0;
            bit_first <= 1'b0;
        end else if (bit_en) begin
            idx_q     <= idx_d;
            sel_cur   <= sel_d;
            ser_bit   <= bit_d;
            bit_first <= at_wrap;
        end
    end

    assert_idx_in_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= sel_last(sel_cur));

    assert_hold_between_enables_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(ser_bit) && $stable(bit_first) && $stable(sel_cur)));

    assert_first_follows_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_first |-> (idx_q == IDX_W'(1)));

    assert_sel_fixed_in_period_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !at_wrap) |=> $stable(sel_cur));

endmodule

// File: rtl/cvsd_refgen_mon.sv
`timescale 1ns/1ps
module cvsd_refgen_mon
    import cvsd_refgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             at_wrap,
    input  sel_t             sel_cur,
    input  sel_t             sel_req,
    input  logic             ovl_in,
    output logic [CNT_W-1:0] duty_cnt,
    output logic             duty_valid,
    output logic             density_err
);

    typedef enum logic [1:0] {
        M_IDLE  = 2'd0,
        M_WARM  = 2'd1,
        M_CHECK = 2'd2
    } mon_state_t;

    mon_state_t       state_q;
    mon_state_t       state_d;
    logic [CNT_W-1:0] tally_q;
    logic [CNT_W-1:0] tally_sum;
    logic             closing;

    always_comb begin
        tally_sum = tally_q + CNT_W'(ovl_in);
        closing   = at_wrap && (state_q != M_IDLE);
        state_d   = state_q;
        if (at_wrap) begin
            unique case (state_q)
                M_IDLE:           state_d = M_WARM;
                M_WARM, M_CHECK:  state_d = (sel_req == sel_cur) ? M_CHECK : M_WARM;
                default:          state_d = M_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= M_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tally_q     <= '0;
            duty_cnt    <= '0;
            duty_valid  <= 1'b0;
            density_err <= 1'b0;
        end else begin
            duty_valid  <= closing;
            density_err <= closing && (state_q == M_CHECK) && (tally_sum != sel_runs(sel_cur));
            if (closing) duty_cnt <= tally_sum;
            if (at_wrap)     tally_q <= '0;
            else if (bit_en) tally_q <= tally_sum;
        end
    end

    assert_report_after_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        duty_valid |-> $past(at_wrap));

    assert_tally_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
        duty_valid |-> (duty_cnt <= CNT_W'(LONG_LEN)));

    assert_err_needs_report_R10: assert property (@(posedge clk) disable iff (!rst_n)
        density_err |-> duty_valid);

    assert_warm_period_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (at_wrap && state_q == M_WARM) |=> !density_err);

endmodule

// File: rtl/cvsd_refgen.sv
`timescale 1ns/1ps
module cvsd_refgen
    import cvsd_refgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             rate_sel,
    input  logic             dens_sel,
    input  logic             ovl_in,
    output logic             ser_bit,
    output logic             bit_first,
    output logic             act_rate,
    output logic             act_dens,
    output logic [CNT_W-1:0] duty_cnt,
    output logic             duty_valid,
    output logic             density_err
);

    sel_t sel_req;
    sel_t sel_cur;
    logic at_wrap;

    assign sel_req  = '{wide: rate_sel, dense: dens_sel};
    assign act_rate = sel_cur.wide;
    assign act_dens = sel_cur.dense;

    cvsd_refgen_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .sel_req   (sel_req),
        .ser_bit   (ser_bit),
        .bit_first (bit_first),
        .sel_cur   (sel_cur),
        .at_wrap   (at_wrap)
    );

    cvsd_refgen_mon u_mon (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_en      (bit_en),
        .at_wrap     (at_wrap),
        .sel_cur     (sel_cur),
        .sel_req     (sel_req),
        .ovl_in      (ovl_in),
        .duty_cnt    (duty_cnt),
        .duty_valid  (duty_valid),
        .density_err (density_err)
    );

endmodule

// File: tb/tb_cvsd_refgen.sv
`timescale 1ns/1ps
module tb_cvsd_refgen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       rate_sel = 1'b0;
    logic       dens_sel = 1'b0;
    logic       ovl_in = 1'b0;
    logic       ser_bit, bit_first, act_rate, act_dens, duty_valid, density_err;
    logic [5:0] duty_cnt;

    always #10 clk = ~clk;

    cvsd_refgen dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rate_sel(rate_sel),
        .dens_sel(dens_sel), .ovl_in(ovl_in), .ser_bit(ser_bit),
        .bit_first(bit_first), .act_rate(act_rate), .act_dens(act_dens),
        .duty_cnt(duty_cnt), .duty_valid(duty_valid), .density_err(density_err)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct { logic b; logic f; logic r; logic d; } bit_item_t;
    typedef struct { int c; logic e; logic chk; } rep_item_t;
    bit_item_t bq[$];
    rep_item_t rq[$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic pat(logic r, logic d, int i);
        logic [39:0] w;
        case ({r, d})
            2'b00:   w = {20'hDB492, 20'h0};
            2'b01:   w = {20'hFB412, 20'h0};
            2'b10:   w = 40'hDB54924AB6;
            default: w = 40'hFDAA10255E;
        endcase
        return w[39 - i];
    endfunction

    function automatic int plen(logic r);
        return r ? 40 : 20;
    endfunction

    function automatic int exp_runs(logic r, logic d);
        return d ? (r ? 12 : 6) : 0;
    endfunction

    function automatic string pat_tag(logic r, logic d);
        return r ? (d ? "R5" : "R4") : (d ? "R3" : "R2");
    endfunction

    // reference model state
    int       m_idx = 0;
    logic     m_r = 0, m_d = 0;
    logic [2:0] m_hist = 3'b000;
    int       m_nbits = 0;
    int       m_cnt = 0;
    logic     m_started = 0;
    logic     m_chk = 0;
    bit       flip_ovl = 0;

    // driver: pushes expectations, then presents one enable
    task automatic step(input int gap);
        logic ovl;
        logic b;
        int   tot;
        ovl = (m_nbits >= 3) && ((m_hist == 3'b000) || (m_hist == 3'b111));
        if (flip_ovl) begin
            ovl = ~ovl;
            flip_ovl = 0;
        end
        if (m_idx == 0) begin
            if (m_started) begin
                tot = m_cnt + int'(ovl);
                rq.push_back('{tot, m_chk && (tot != exp_runs(m_r, m_d)), m_chk});
            end
            m_chk = m_started && (rate_sel == m_r) && (dens_sel == m_d);
            m_r = rate_sel;
            m_d = dens_sel;
            m_cnt = 0;
            m_started = 1;
        end else begin
            m_cnt += int'(ovl);
        end
        b = pat(m_r, m_d, m_idx);
        bq.push_back('{b, (m_idx == 0), m_r, m_d});
        m_hist = {m_hist[1:0], b};
        m_nbits++;
        m_idx = (m_idx == plen(m_r) - 1) ? 0 : m_idx + 1;
        ovl_in = ovl;
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        ovl_in = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    // monitor: pops and compares as results appear
    logic en_d = 1'b0;
    logic hold_bit = 1'b0, hold_first = 1'b0;
    always @(posedge clk) en_d <= bit_en;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (en_d) begin
                if (bq.size() == 0) begin
                    chk(0, "R6 unexpected bit update", 1, 0);
                end else begin
                    bit_item_t it;
                    it = bq.pop_front();
                    chk(ser_bit === it.b, pat_tag(it.r, it.d), int'(ser_bit), int'(it.b));
                    chk(bit_first === it.f, "R7 bit_first", int'(bit_first), int'(it.f));
                    chk({act_rate, act_dens} === {it.r, it.d}, "R8 act selection",
                        int'({act_rate, act_dens}), int'({it.r, it.d}));
                end
                hold_bit = ser_bit;
                hold_first = bit_first;
            end else begin
                chk((ser_bit === hold_bit) && (bit_first === hold_first), "R6 hold",
                    int'({ser_bit, bit_first}), int'({hold_bit, hold_first}));
            end
            if (duty_valid) begin
                if (rq.size() == 0) begin
                    chk(0, "R9 unexpected report", 1, 0);
                end else begin
                    rep_item_t rp;
                    rp = rq.pop_front();
                    chk(int'(duty_cnt) == rp.c, "R9 duty_cnt", int'(duty_cnt), rp.c);
                    chk(density_err === rp.e, rp.chk ? "R10 density_err" : "R11 warm density_err",
                        int'(density_err), int'(rp.e));
                end
            end else if (density_err) begin
                chk(0, "R10 density_err without report", 1, 0);
            end
        end
    end

    task automatic check_idle_outputs(input string when_s);
        chk(ser_bit === 1'b0 && bit_first === 1'b0, {"R1 bits ", when_s},
            int'({ser_bit, bit_first}), 0);
        chk(act_rate === 1'b0 && act_dens === 1'b0, {"R1 selection ", when_s},
            int'({act_rate, act_dens}), 0);
        chk(duty_cnt === 6'd0 && duty_valid === 1'b0 && density_err === 1'b0,
            {"R1 monitor ", when_s}, int'({duty_cnt, duty_valid, density_err}), 0);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check_idle_outputs("in reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_idle_outputs("after reset");

        // R2: 16 kbps 0% word, three periods
        rate_sel = 1'b0; dens_sel = 1'b0;
        repeat (60) step(2);

        // R8: density change in mid-period, then R3
        repeat (7) step(1);
        dens_sel = 1'b1;
        repeat (13) step(2);
        repeat (60) step(1);

        // R4: change exactly at a boundary, back-to-back enables
        rate_sel = 1'b1; dens_sel = 1'b0;
        repeat (120) step(0);

        // R5 then R10: one corrupted flag in a checked period
        dens_sel = 1'b1;
        repeat (80) step(3);
        step(2);
        repeat (5) step(2);
        flip_ovl = 1;
        step(2);
        repeat (33) step(2);
        repeat (20) step(1);

        // R8/R11: rate change in mid-period, new warm period
        rate_sel = 1'b0;
        repeat (20) step(1);
        repeat (40) step(2);
        step(1);

        repeat (6) @(negedge clk);
        chk(bq.size() == 0, "R6 pending bits", bq.size(), 0);
        chk(rq.size() == 0, "R9 pending reports", rq.size(), 0);
        finish_run();
    end

endmodule